// File: doc/BRIEF.md
# Multiplexed Grid Scan and Dimming Generator

This block generates the scan timing for a vacuum-fluorescent style display multiplexed over two or three grids. The oscillator clock is divided into ticks. Each tick is four clock cycles. Every grid owns a slot of 1024 ticks. In duplex mode the grids take turns in the order 1, 2. In triplex mode the order is 1, 2, 3. The grid line of the current slot is pulled low for a brightness-controlled number of ticks. The 32 segment lines carry the data word of that grid inside a window that opens 3 ticks into the slot.

As a master, the block runs the scan and the brightness PWM itself. It also drives a dimming pulse and a 2-bit grid code, so a cascaded second device can follow the same phase. As a slave, it keeps all grids off and its own timing outputs quiet. Its segment lines then follow an external dimming pulse, gated by whichever data word the external grid code selects. The three segment data words and the 10-bit brightness value come from latches outside this block.

Top module: `vfd_scan_gen`

## Requirements
- R1: While rst_ni is low, grid_n_o is 3'b111 and seg_o, dim_o and sync_o are all zero.
- R2: A tick lasts 4 clock cycles and a slot lasts 1024 ticks. Counting starts at tick 0 of grid 1 on the first rising edge after reset is released.
- R3: Slots are scanned in the order grid 1, grid 2, then grid 3 only when triplex is selected (duplex_i=0), and then the order wraps. A duplex cycle is 2048 ticks and a triplex cycle is 3072 ticks.
- R4: In master mode, grid g is driven active low on grid_n_o bit g-1 during ticks 0 to on-1 of its own slot, where on = min(dim_val_i, 1016). At most one grid line is low at any time.
- R5: Any dim_val_i of 1016 or more acts as 1016, so the last 8 ticks of every slot have all grid lines high.
- R6: In master mode, when on is greater than 0, dim_o is high during ticks 3 to on+5 of each slot (1019 ticks at full brightness) and low otherwise. When on is 0, dim_o stays low.
- R7: In master mode, seg_o equals the data word of the current grid (latch1_i, latch2_i or latch3_i) while dim_o is high, and is zero otherwise.
- R8: In master mode, sync_o carries the current grid number (2'd1, 2'd2 or 2'd3) while dim_o is high, and 2'd0 otherwise.
- R9: In slave mode (master_i=0), grid_n_o is 3'b111, dim_o is 0 and sync_o is 2'd0.
- R10: In slave mode, seg_o is combinational in the inputs. When dim_i is 1, seg_o shows the word chosen by sync_i (code 1 selects latch1_i, 2 selects latch2_i, 3 selects latch3_i, 0 selects none, giving zero). When dim_i is 0, seg_o is zero.
- R11: duplex_i and master_i are sampled on the clock. A sampled change restarts the scan at tick 0 of grid 1 on that same edge.
- R12: In master mode, dim_i and sync_i have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duplex_i | input | 1 | 1 selects two grids, 0 selects three |
| master_i | input | 1 | 1 selects master, 0 selects slave |
| dim_val_i | input | 10 | Brightness in 1/1024 slot units |
| latch1_i | input | 32 | Segment word for grid 1 |
| latch2_i | input | 32 | Segment word for grid 2 |
| latch3_i | input | 32 | Segment word for grid 3 |
| dim_i | input | 1 | External dimming pulse (slave) |
| sync_i | input | 2 | External grid code (slave) |
| grid_n_o | output | 3 | Grid drives, active low, bit 0 is grid 1 |
| seg_o | output | 32 | Segment drives, high lights |
| dim_o | output | 1 | Dimming pulse for a slave |
| sync_o | output | 2 | Grid code for a slave |

## Verification
In master mode, every output is a combinational function of the divider, tick and grid registers. After the n-th rising edge since reset release or since a restart, the expected tick is n/4 mod 1024 and the expected grid is (n/4096) mod the grid count. The bench keeps its own edge count and its own registered copy of the mode selects. It compares every output against that model at each falling edge, so samples fall half a cycle after the update. Slave-mode segment outputs respond to sync_i and dim_i with no register. Those inputs are therefore changed at one falling edge and checked at the next. A mode change takes effect on the following rising edge. The bench resets its edge count on that same edge, and an explicit check confirms that grid 1 is active at the first sample afterwards.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
  localparam int unsigned NUM_GRIDS = 3;
  localparam int unsigned GRID_W    = 2;
  typedef logic [GRID_W-1:0] grid_idx_t;
endpackage

// File: rtl/scan_timebase.sv
module scan_timebase
  import vfd_scan_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned SLOT_W   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              duplex_i,
  input  logic              master_i,
  output logic              duplex_q_o,
  output logic              master_q_o,
  output logic [SLOT_W-1:0] slot_t_o,
  output grid_idx_t         grid_o
);
  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] t_q;
  grid_idx_t         grid_q;
  logic              dup_q, mas_q;
  logic              tick, restart, last_grid;

  assign tick      = (div_q == DIV_W'(TICK_DIV - 1));
  assign restart   = (duplex_i != dup_q) || (master_i != mas_q);
  assign last_grid = dup_q ? (grid_q == grid_idx_t'(1)) : (grid_q == grid_idx_t'(NUM_GRIDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      t_q    <= '0;
      grid_q <= '0;
      dup_q  <= 1'b0;
      mas_q  <= 1'b1;
    end else if (restart) begin
      div_q  <= '0;
      t_q    <= '0;
      grid_q <= '0;
      dup_q  <= duplex_i;
      mas_q  <= master_i;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        t_q <= t_q + 1'b1;
        if (&t_q) grid_q <= last_grid ? '0 : grid_q + 1'b1;
      end
    end
  end

  assign duplex_q_o = dup_q;
  assign master_q_o = mas_q;
  assign slot_t_o   = t_q;
  assign grid_o     = grid_q;

  p_tick_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart && tick) |=> (t_q == SLOT_W'($past(t_q) + 1'b1)));
  p_tick_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart && !tick) |=> $stable(t_q));
  p_no_grid3_duplex_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_q |-> (grid_q != grid_idx_t'(2)));
  p_grid_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grid_q != grid_idx_t'(3));
  p_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (t_q == '0 && grid_q == '0 && div_q == '0));
endmodule

// File: rtl/dim_window.sv
module dim_window #(
  parameter int unsigned SLOT_W      = 10,
  parameter int unsigned BLANK_TICKS = 8,
  parameter int unsigned SEG_LEAD    = 3,
  parameter int unsigned SEG_TAIL    = 3
) (
  input  logic [SLOT_W-1:0] dim_val_i,
  input  logic [SLOT_W-1:0] slot_t_i,
  output logic              grid_act_o,
  output logic              seg_win_o
);
  localparam int unsigned SLOT  = 1 << SLOT_W;
  localparam int unsigned END_W = SLOT_W + 1;
  localparam logic [SLOT_W-1:0] DIM_MAX = SLOT_W'(SLOT - BLANK_TICKS);

  logic [SLOT_W-1:0] on_ticks;
  logic [END_W-1:0]  seg_end;

  assign on_ticks   = (dim_val_i > DIM_MAX) ? DIM_MAX : dim_val_i;
  assign seg_end    = {1'b0, on_ticks} + END_W'(SEG_LEAD + SEG_TAIL);
  assign grid_act_o = slot_t_i < on_ticks;
  assign seg_win_o  = (on_ticks != '0) && (slot_t_i >= SLOT_W'(SEG_LEAD))
                      && ({1'b0, slot_t_i} < seg_end);
endmodule

// File: rtl/seg_mux.sv
module seg_mux
  import vfd_scan_pkg::*;
#(
  parameter int unsigned SEG_W = 32
) (
  input  logic                            master_i,
  input  logic                            win_i,
  input  grid_idx_t                       grid_i,
  input  logic [NUM_GRIDS-1:0][SEG_W-1:0] words_i,
  input  logic                            dim_i,
  input  grid_idx_t                       sync_i,
  output logic [SEG_W-1:0]                seg_o
);
  logic [SEG_W-1:0] own_word, ext_word;

  always_comb begin
    own_word = '0;
    ext_word = '0;
    for (int g = 0; g < NUM_GRIDS; g++) begin
      if (grid_i == grid_idx_t'(g))     own_word = words_i[g];
      if (sync_i == grid_idx_t'(g + 1)) ext_word = words_i[g];
    end
    if (master_i) seg_o = win_i ? own_word : '0;
    else          seg_o = dim_i ? ext_word : '0;
  end
endmodule

// File: rtl/vfd_scan_gen.sv
module vfd_scan_gen
  import vfd_scan_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 4,
  parameter int unsigned DIM_W       = 10,
  parameter int unsigned SEG_W       = 32,
  parameter int unsigned BLANK_TICKS = 8,
  parameter int unsigned SEG_LEAD    = 3,
  parameter int unsigned SEG_TAIL    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             duplex_i,
  input  logic             master_i,
  input  logic [DIM_W-1:0] dim_val_i,
  input  logic [SEG_W-1:0] latch1_i,
  input  logic [SEG_W-1:0] latch2_i,
  input  logic [SEG_W-1:0] latch3_i,
  input  logic             dim_i,
  input  logic [1:0]       sync_i,
  output logic [2:0]       grid_n_o,
  output logic [SEG_W-1:0] seg_o,
  output logic             dim_o,
  output logic [1:0]       sync_o
);
  localparam int unsigned SLOT = 1 << DIM_W;

  logic             duplex_q, master_q, grid_act, seg_win, live;
  logic [DIM_W-1:0] slot_t;
  grid_idx_t        grid_idx;
  logic [SEG_W-1:0] seg_raw;
  logic [NUM_GRIDS-1:0][SEG_W-1:0] words;

  assign words = {latch3_i, latch2_i, latch1_i};

  scan_timebase #(.TICK_DIV(TICK_DIV), .SLOT_W(DIM_W)) u_timebase (
    .clk_i, .rst_ni, .duplex_i, .master_i,
    .duplex_q_o(duplex_q), .master_q_o(master_q),
    .slot_t_o(slot_t), .grid_o(grid_idx)
  );

  dim_window #(.SLOT_W(DIM_W), .BLANK_TICKS(BLANK_TICKS),
               .SEG_LEAD(SEG_LEAD), .SEG_TAIL(SEG_TAIL)) u_window (
    .dim_val_i, .slot_t_i(slot_t), .grid_act_o(grid_act), .seg_win_o(seg_win)
  );

  seg_mux #(.SEG_W(SEG_W)) u_mux (
    .master_i(master_q), .win_i(seg_win), .grid_i(grid_idx), .words_i(words),
    .dim_i, .sync_i, .seg_o(seg_raw)
  );

  assign live = rst_ni && master_q;

  for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_grid
    assign grid_n_o[g] = !(live && grid_act && grid_idx == grid_idx_t'(g));
  end

  assign dim_o  = live && seg_win;
  assign sync_o = dim_o ? 2'(grid_idx + 1'b1) : 2'd0;
  assign seg_o  = rst_ni ? seg_raw : '0;

  always @(negedge clk_i) begin
    if (!rst_ni) a_reset_idle_r1: assert (grid_n_o == 3'b111 && seg_o == '0 && !dim_o && sync_o == 2'd0);
  end

  p_one_grid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~grid_n_o) <= 1);
  p_blank_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_t >= DIM_W'(SLOT - BLANK_TICKS)) |-> (grid_n_o == 3'b111));
  p_dark_seg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_q && !dim_o) |-> (seg_o == '0));
  p_sync_win_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_q |-> (dim_o == (sync_o != 2'd0)));
  p_slave_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_q |-> (grid_n_o == 3'b111 && !dim_o && sync_o == 2'd0));
endmodule

// File: tb/vfd_scan_gen_tb.sv
module vfd_scan_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int SLOT = 1024;
  localparam int DMAX = 1016;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        duplex = 1'b0, master = 1'b1;
  logic [9:0]  dim_val = '0;
  logic [31:0] l1 = 32'hA5A5_0F0F, l2 = 32'h1234_5678, l3 = 32'hFFFF_0001;
  logic        dim_in = 1'b0;
  logic [1:0]  sync_in = 2'd0;
  logic [2:0]  grid_n;
  logic [31:0] seg;
  logic        dim_out;
  logic [1:0]  sync_out;

  int checks = 0, fails = 0;
  int k = 0;
  logic dup_m = 1'b0, mas_m = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfd_scan_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .duplex_i(duplex), .master_i(master),
    .dim_val_i(dim_val), .latch1_i(l1), .latch2_i(l2), .latch3_i(l3),
    .dim_i(dim_in), .sync_i(sync_in), .grid_n_o(grid_n), .seg_o(seg),
    .dim_o(dim_out), .sync_o(sync_out)
  );

  // bench timeline: edge count since release or restart (R2, R11)
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      k <= 0; dup_m <= 1'b0; mas_m <= 1'b1;
    end else if (duplex != dup_m || master != mas_m) begin
      k <= 0; dup_m <= duplex; mas_m <= master;
    end else k <= k + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s k=%0d actual=%h expected=%h", tag, k, act, exp);
    end
  endtask

  task automatic compare_model(input string ctx);
    logic [2:0]  e_grid;
    logic [31:0] e_seg, word;
    logic        e_dim;
    logic [1:0]  e_sync;
    int tk, t, g, ng, on;
    e_grid = 3'b111; e_seg = '0; e_dim = 1'b0; e_sync = 2'd0;
    if (rst_ni) begin
      if (mas_m) begin
        tk = k / TDIV; t = tk % SLOT; ng = dup_m ? 2 : 3; g = (tk / SLOT) % ng;
        on = (dim_val > DMAX) ? DMAX : int'(dim_val);
        if (t < on) e_grid[g] = 1'b0;
        e_dim = (on > 0) && (t >= 3) && (t < on + 6);
        word = (g == 0) ? l1 : (g == 1) ? l2 : l3;
        if (e_dim) begin e_seg = word; e_sync = 2'(g + 1); end
      end else begin
        word = (sync_in == 2'd1) ? l1 : (sync_in == 2'd2) ? l2 : (sync_in == 2'd3) ? l3 : 32'd0;
        e_seg = dim_in ? word : 32'd0;
      end
    end
    chk({ctx, " R3/R4 grid"}, 32'(grid_n), 32'(e_grid));
    chk({ctx, " R7/R10 seg"}, seg, e_seg);
    chk({ctx, " R6 dim_o"}, 32'(dim_out), 32'(e_dim));
    chk({ctx, " R8 sync_o"}, 32'(sync_out), 32'(e_sync));
  endtask

  task automatic run_span(input int n, input string ctx, input bit jitter);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_model(ctx);
      if (jitter) begin dim_in = ~dim_in; sync_in = 2'(sync_in + 2'd1 + 2'(i % 3)); end
    end
  endtask

  task automatic t_reset;
    dim_val = 10'd1016;
    repeat (3) @(negedge clk);
    chk("R1 grid", 32'(grid_n), 32'h7);
    chk("R1 seg", seg, 32'd0);
    chk("R1 dim_o", 32'(dim_out), 32'd0);
    chk("R1 sync_o", 32'(sync_out), 32'd0);
    dim_val = 10'd500;
    rst_ni = 1'b1;
  endtask

  task automatic t_triplex_mid;   // R2 R3 R4 R6 R7 R8
    run_span(3 * SLOT * TDIV + 200, "triplex dim500", 1'b0);
  endtask

  task automatic t_clamp;         // R5
    dim_val = 10'd1023;
    run_span(SLOT * TDIV, "R5 clamp", 1'b0);
  endtask

  task automatic t_dim_zero;      // R6 zero
    dim_val = 10'd0;
    run_span(SLOT * TDIV, "R6 dim zero", 1'b0);
  endtask

  task automatic t_duplex_restart; // R11 R3
    @(negedge clk);
    dim_val = 10'd1016;
    duplex = 1'b1;
    @(negedge clk);
    chk("R11 restart grid1", 32'(grid_n), 32'h6);
    compare_model("R11 restart");
    run_span(2 * SLOT * TDIV + 100, "R3 duplex", 1'b0);
  endtask

  task automatic t_master_ignore; // R12
    run_span(SLOT * TDIV, "R12 ignore ext", 1'b1);
    dim_in = 1'b0; sync_in = 2'd0;
  endtask

  task automatic t_slave;         // R9 R10
    master = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      for (int d = 0; d < 2; d++) begin
        sync_in = 2'(c); dim_in = 1'(d);
        @(negedge clk);
        chk("R9 slave grid", 32'(grid_n), 32'h7);
        chk("R9 slave dim/sync", {29'd0, dim_out, sync_out}, 32'd0);
        compare_model("R10 slave");
      end
    end
    dim_in = 1'b0; sync_in = 2'd0;
    master = 1'b1;
    @(negedge clk);
    run_span(200, "R11 back to master", 1'b0);
  endtask

  initial begin
    t_reset();
    t_triplex_mid();
    t_clamp();
    t_dim_zero();
    t_duplex_restart();
    t_master_ignore();
    t_slave();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule